// File: doc/BRIEF.md
# Valid-Qualified Bus Crossing Synchronizer

This block moves a multi-bit word from a slow source clock domain into a much faster destination domain. None of the bus bits pass through a synchronizer of their own. The source registers the word and holds it unchanged. After a settling margin of a configurable number of source cycles, it raises one qualifier bit. That qualifier is the only signal that passes through a multi-flop synchronizer. When the synchronized qualifier rises in the destination domain, the bus has been stable for a long time. The destination then captures the whole word at once and emits it with a single-cycle strobe.

On the source side, words enter through a valid/ready handshake (`src_load` / `src_ready`). A word is taken on a source clock edge where both are high. `src_ready` then stays low while the word is held, while the qualifier is high, and while the qualifier is held low again for the same margin. This guarantees that the receiver sees every low phase. A load offered while `src_ready` is low is not taken, and the source may keep `src_load` asserted until it is. The destination side has no back-pressure: every strobe on `dst_valid` must be consumed in the cycle it appears. The destination clock must run several times faster than the source clock.

Top module: `bus_sync_xfer`

## Requirements
- R1: While both resets are asserted (active low), `src_ready` is 1, `dst_valid` is 0 and `dst_data` is all zeros.
- R2: A word is accepted on a `src_clk` rising edge where `src_ready` and `src_load` are both 1. `src_ready` is 0 from the next cycle on, for exactly 3*SETTLE_CYC source cycles, and then returns to 1.
- R3: `src_load` has no effect while `src_ready` is 0. No extra word is delivered, and the word in flight is not altered.
- R4: The held word stays stable from acceptance until the source is ready again. The qualifier rises exactly SETTLE_CYC source cycles after acceptance, so no strobe can appear earlier than SETTLE_CYC source periods after the accepting edge.
- R5: The qualifier stays high for exactly SETTLE_CYC source cycles. It then stays low for at least SETTLE_CYC source cycles before another word can be accepted.
- R6: Each accepted word produces exactly one `dst_valid` pulse, one `dst_clk` cycle wide, with `dst_data` equal to that word. Words are delivered in acceptance order.
- R7: `dst_data` holds the most recently delivered word, and does not change, on every `dst_clk` cycle where `dst_valid` is 0.
- R8: A word is delivered at the destination before the source accepts the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_data | input | DATA_W | Word offered by the source |
| src_load | input | 1 | Source offers `src_data` (valid) |
| src_ready | output | 1 | Block can take a new word (ready) |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_data | output | DATA_W | Captured word, held until the next delivery |
| dst_valid | output | 1 | One-cycle strobe marking a newly captured word |

## Verification
A source sequencer stuck in one phase, or a miscounted margin, shows at `src_ready` within one source cycle of the expected return. A wrong hold register or a bad capture edge shows as a wrong `dst_data` at the very next strobe. A broken edge detector, or a qualifier that pulses twice, shows as a second or missing strobe. That is caught either in the following `dst_clk` cycle or when the next word is accepted while one is still owed. An early qualifier shows as a strobe arriving sooner than the settling window allows after acceptance.

// File: rtl/bsx_pkg.sv
package bsx_pkg;

  // Source-side sequencing phases for one transfer.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_HIGH   = 2'd2,
    PH_GAP    = 2'd3
  } bsx_phase_e;

endpackage

// File: rtl/bsx_src.sv
module bsx_src
  import bsx_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SETTLE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_load,
  output logic              ready,
  output logic [DATA_W-1:0] hold_data,
  output logic              qual
);

  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam int RUN_W = CNT_W + 2;
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  bsx_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] hold_q;
  logic              qual_q;
  logic              cnt_done;

  assign cnt_done  = (cnt_q == CNT_LAST);
  assign ready     = (phase_q == PH_IDLE);
  assign hold_data = hold_q;
  assign qual      = qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      hold_q  <= '0;
      qual_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (in_load) begin
            hold_q  <= in_data;
            cnt_q   <= '0;
            phase_q <= PH_SETTLE;
          end
        end
        PH_SETTLE: begin
          if (cnt_done) begin
            cnt_q   <= '0;
            qual_q  <= 1'b1;
            phase_q <= PH_HIGH;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_done) begin
            cnt_q   <= '0;
            qual_q  <= 1'b0;
            phase_q <= PH_GAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_GAP: begin
          if (cnt_done) begin
            cnt_q   <= '0;
            phase_q <= PH_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // Run-length counters of the qualifier level, used only by the checks below.
  logic [RUN_W-1:0] low_run_q, high_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q  <= '0;
      high_run_q <= '0;
    end else begin
      low_run_q  <= qual_q ? '0 : ((low_run_q == RUN_MAX) ? low_run_q : low_run_q + 1'b1);
      high_run_q <= !qual_q ? '0 : ((high_run_q == RUN_MAX) ? high_run_q : high_run_q + 1'b1);
    end
  end

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && in_load) |=> !ready);

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(hold_q));

  // R4
  qual_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_q) |-> (low_run_q >= RUN_W'(SETTLE_CYC)));

  // R5
  qual_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qual_q) |-> (high_run_q == RUN_W'(SETTLE_CYC)));

endmodule

// File: rtl/bsx_sync.sv
module bsx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/bsx_dst.sv
module bsx_dst #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qual_s,
  input  logic [DATA_W-1:0] bus,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);

  logic              prev_q;
  logic              rise;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  assign rise      = qual_s & ~prev_q;
  assign out_data  = data_q;
  assign out_valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      prev_q  <= qual_s;
      valid_q <= rise;
      if (rise) data_q <= bus;
    end
  end

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(data_q));

endmodule

// File: rtl/bus_sync_xfer.sv
module bus_sync_xfer #(
  parameter int DATA_W      = 16,
  parameter int SETTLE_CYC  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_load,
  output logic              src_ready,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic [DATA_W-1:0] dst_data,
  output logic              dst_valid
);

  logic [DATA_W-1:0] held_bus;
  logic              qual_src;
  logic              qual_dst;

  bsx_src #(
    .DATA_W     (DATA_W),
    .SETTLE_CYC (SETTLE_CYC)
  ) i_src (
    .clk       (src_clk),
    .rst_n     (src_rst_n),
    .in_data   (src_data),
    .in_load   (src_load),
    .ready     (src_ready),
    .hold_data (held_bus),
    .qual      (qual_src)
  );

  bsx_sync #(
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d     (qual_src),
    .q     (qual_dst)
  );

  bsx_dst #(
    .DATA_W (DATA_W)
  ) i_dst (
    .clk       (dst_clk),
    .rst_n     (dst_rst_n),
    .qual_s    (qual_dst),
    .bus       (held_bus),
    .out_data  (dst_data),
    .out_valid (dst_valid)
  );

endmodule

// File: tb/test_bus_sync_xfer.sv
`timescale 1ns/1ps
module test_bus_sync_xfer;

  localparam int DW  = 16;
  localparam int S   = 3;
  localparam real DST_HALF = 2.5;
  localparam real SRC_HALF = 18.5;
  localparam real SRC_PER  = 37.0;

  logic          src_clk = 0, dst_clk = 0;
  logic          src_rst_n = 0, dst_rst_n = 0;
  logic [DW-1:0] src_data = '0;
  logic          src_load = 0;
  logic          src_ready;
  logic [DW-1:0] dst_data;
  logic          dst_valid;

  always #(SRC_HALF) src_clk = ~src_clk;
  always #(DST_HALF) dst_clk = ~dst_clk;

  bus_sync_xfer #(.DATA_W(DW), .SETTLE_CYC(S), .SYNC_STAGES(2)) i_bus_sync_xfer (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_data(src_data),
    .src_load(src_load), .src_ready(src_ready),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_data(dst_data), .dst_valid(dst_valid)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model: source busy window and pending words.
  int            busy = 0;
  logic [DW-1:0] exp_q[$];
  realtime       acc_t[$];
  logic [DW-1:0] last_word = '0;
  bit            prev_valid = 0;
  int            accepted = 0, delivered = 0;

  always @(posedge src_clk) begin
    if (!src_rst_n) busy = 0;
    else if (busy > 0) busy--;
    else if (src_load) begin
      // R8: previous word must already be delivered
      chk(exp_q.size() == 0, "R8", "word pending at next accept", exp_q.size(), 0);
      exp_q.push_back(src_data);
      acc_t.push_back($realtime);
      accepted++;
      busy = 3 * S;
    end
  end

  always @(negedge src_clk) begin
    if (src_rst_n && dst_rst_n)
      // R2 / R5 ready window length
      chk(src_ready === (busy == 0), "R2", "src_ready", src_ready, busy == 0);
  end

  always @(negedge dst_clk) begin
    if (src_rst_n && dst_rst_n) begin
      if (dst_valid === 1'b1) begin
        // R6 word, order, single-cycle width
        chk(exp_q.size() > 0, "R6", "strobe without accepted word", 1, 0);
        chk(!prev_valid, "R6", "strobe wider than one cycle", 1, 0);
        if (exp_q.size() > 0) begin
          chk(dst_data === exp_q[0], "R6", "dst_data", dst_data, exp_q[0]);
          // R4 qualifier must wait the settling window
          chk(($realtime - acc_t[0]) >= S * SRC_PER, "R4", "strobe too early",
              32'($rtoi($realtime - acc_t[0])), 32'($rtoi(S * SRC_PER)));
          void'(exp_q.pop_front());
          void'(acc_t.pop_front());
          delivered++;
        end
        last_word = dst_data;
      end else begin
        // R7 hold between strobes
        chk(dst_data === last_word, "R7", "dst_data changed without strobe", dst_data, last_word);
      end
      prev_valid = (dst_valid === 1'b1);
    end
  end

  task automatic offer(input logic [DW-1:0] w);
    @(negedge src_clk);
    while (!src_ready) @(negedge src_clk);
    src_data = w;
    src_load = 1;
    @(negedge src_clk);
    src_load = 0;
    // R3: junk load while busy must be ignored
    src_data = ~w;
    src_load = 1;
    @(negedge src_clk);
    src_load = 0;
  endtask

  initial begin
    repeat (4) @(negedge src_clk);
    // R1 reset state
    chk(src_ready === 1'b1, "R1", "src_ready in reset", src_ready, 1);
    chk(dst_valid === 1'b0, "R1", "dst_valid in reset", dst_valid, 0);
    chk(dst_data === '0, "R1", "dst_data in reset", dst_data, 0);
    src_rst_n = 1;
    dst_rst_n = 1;
    repeat (2) @(negedge src_clk);

    // Corner words
    offer(16'h0000);
    offer(16'hFFFF);
    offer(16'hA5A5);
    offer(16'h5A5A);
    offer(16'h0001);
    offer(16'h8000);

    // Load held high with data changing every cycle (R3)
    for (int i = 0; i < 80; i++) begin
      @(negedge src_clk);
      src_load = 1;
      src_data = DW'(16'h1234 + i * 16'h0101);
    end
    @(negedge src_clk);
    src_load = 0;

    // Random sparse offers
    for (int i = 0; i < 600; i++) begin
      @(negedge src_clk);
      src_load = ($urandom % 10) < 4;
      src_data = DW'($urandom);
    end
    @(negedge src_clk);
    src_load = 0;

    repeat (3 * S + 10) @(negedge src_clk);
    // R6 everything accepted was delivered exactly once
    chk(exp_q.size() == 0, "R6", "words never delivered", exp_q.size(), 0);
    chk(delivered == accepted, "R6", "delivered count", delivered, accepted);
    chk(accepted > 20, "R2", "too few accepts", accepted, 21);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge dst_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule